// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into 30-bit physical addresses with 4 KB pages. It holds a small cache of page mappings. Every slot is compared against the page number of each request at once, so a mapping may sit in any slot. Addresses in the top quarter of the virtual space skip the cache and go straight to physical space. A request that cannot be served returns a fault code: no mapping, mapping not valid, or store to a read-only page. The fault also records the page number and the full address in two registers, so that the software fault handler can act on them.

Software manages the cache through four registers: a slot pointer, a page-number register, a frame/flags register and a faulting-address register. Its operations are one-cycle commands: look up a page number, store a mapping into a slot chosen by a free-running counter, load a slot into the registers, and store the registers into the slot named by the pointer. The three writable registers are also loaded directly through a register write port. Privilege checks, the pipeline, the bus and the page-table walk all live outside this block.

Top module: `tlb_mmu`

## Requirements
- R1: A translation request whose page number (vaddr[31:12]) matches the stored page number of a valid slot returns paddr = {slot frame (18 bits), vaddr[11:0]} in the same cycle with fault code 0 (none), whichever slot holds the mapping.
- R2: When vaddr[31:30] == 2'b11 the request is never looked up: paddr = vaddr[29:0], fault code 0, and the faulting-address register is left unchanged.
- R3: A request outside the bypass window that matches no slot returns fault code 1 (miss).
- R4: A match on a slot whose valid flag is 0 returns fault code 2 (invalid). A store that matches a valid slot whose write-enable flag is 0 returns fault code 3 (write-protect). A load from such a slot succeeds.
- R5: On the clock edge that ends a request with a nonzero fault code, the page-number register becomes {vaddr[31:12], 12'h000} and the faulting-address register becomes vaddr.
- R6: Command code 0 (search) compares the page-number register with every slot. On a hit the pointer becomes the slot number with bit 31 clear. On no hit the pointer becomes 32'h8000_0000.
- R7: Command code 1 (random write) stores the page-number and frame/flags registers into the slot held by a counter. After reset the counter holds 4, it advances on every clock, and it wraps from 31 to 4, so slots 0 to 3 are never chosen.
- R8: Command code 2 loads the page-number and frame/flags registers from the slot named by pointer bits [4:0]. Command code 3 stores both registers into that slot. Each command takes effect on the edge where it is strobed.
- R9: Register write select 0 loads the pointer (bit 31 and bits [4:0] are kept, so it reads back {bit31, 26'b0, bits[4:0]}). Select 1 loads the page-number register, and its bits [11:0] read as zero. Select 2 loads the frame/flags register with frame in bits [29:12], write-enable in bit 1 and valid in bit 0, and all other bits read as zero.
- R10: When a faulting request and a command or register write that loads the page-number register fall on the same edge, the fault's page number wins. The command or register write still updates the other registers it targets.
- R11: After reset all four registers read zero and every slot is invalid, with a page number inside the bypass window, so any request outside the window misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_req | input | 1 | Translation request valid |
| xl_vaddr | input | 32 | Virtual address to translate |
| xl_store | input | 1 | 1 = store access, 0 = load |
| xl_paddr | output | 30 | Physical address (zero when faulting) |
| xl_fault | output | 2 | 0 none, 1 miss, 2 invalid, 3 write-protect |
| cmd_valid | input | 1 | Management command strobe |
| cmd_op | input | 2 | 0 search, 1 random write, 2 read slot, 3 write slot |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 pointer, 1 page number, 2 frame/flags, 3 none |
| reg_wdata | input | 32 | Register write data |
| index_o | output | 32 | Slot pointer register |
| entry_hi_o | output | 32 | Page-number register |
| entry_lo_o | output | 32 | Frame/flags register |
| bad_addr_o | output | 32 | Faulting-address register |

## Verification
Two functions can fall in the same cycle: a translation fault and a software update of the page-number register. The update can come from a read-slot command or from a direct register write. The bench strobes each of these on the same edge as a request to an unmapped page. It then checks that the page-number register holds the fault's page, and that the frame/flags register still took the value loaded by the read-slot command. The rest of the bench sweeps all 32 slots with arithmetic mappings and flag patterns, and then issues enough random writes to pass the counter's wrap point.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 30;
    localparam int PAGE_W = 12;
    localparam int REG_W  = 32;
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PFN_W  = PA_W - PAGE_W;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             wen;
        logic             vld;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_MISS    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_WPROT   = 2'd3
    } tlb_fault_e;

    typedef enum logic [1:0] {
        OP_SEARCH  = 2'd0,
        OP_WR_RAND = 2'd1,
        OP_RD_IDX  = 2'd2,
        OP_WR_IDX  = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_HI    = 2'd1,
        SEL_LO    = 2'd2,
        SEL_NONE  = 2'd3
    } tlb_sel_e;

    // Top two address bits both set: direct physical access.
    function automatic logic is_unmapped(input logic [VA_W-1:0] va);
        return &va[VA_W-1:VA_W-2];
    endfunction

    function automatic logic [REG_W-1:0] pack_lo(input logic [PFN_W-1:0] pfn,
                                                 input logic wen, input logic vld);
        return {{(REG_W-PA_W){1'b0}}, pfn, {(PAGE_W-2){1'b0}}, wen, vld};
    endfunction

    function automatic logic [REG_W-1:0] pack_hi(input logic [VPN_W-1:0] vpn);
        return {vpn, {PAGE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
    parameter int N    = 32,
    parameter int RSVD = 4,
    parameter int IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] slot_o
);
    localparam logic [IW-1:0] LO = IW'(RSVD);
    localparam logic [IW-1:0] HI = IW'(N - 1);

    logic [IW-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)          q <= LO;
        else if (q == HI) q <= LO;
        else              q <= q + 1'b1;
    end

    assign slot_o = q;

    p_skip_low_r7: assert property (@(posedge clk) disable iff (rst)
        slot_o >= LO);

    p_step_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot_o == (($past(slot_o) == HI) ? LO : $past(slot_o) + 1'b1)));

endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest set bit wins; aliased slots are software's error.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  tlb_entry_t       wdata,
    input  logic [IW-1:0]    ridx,
    output tlb_entry_t       rdata,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output tlb_entry_t       lk_entry,
    input  logic [VPN_W-1:0] sr_vpn,
    output logic             sr_hit,
    output logic [IW-1:0]    sr_idx
);
    tlb_entry_t    ent_q [N];
    logic [N-1:0]  lk_m;
    logic [N-1:0]  sr_m;
    logic [IW-1:0] lk_idx;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                ent_q[i].vpn <= {2'b11, (VPN_W-2)'(i)};
                ent_q[i].pfn <= '0;
                ent_q[i].wen <= 1'b0;
                ent_q[i].vld <= 1'b0;
            end else if (we && widx == IW'(i)) begin
                ent_q[i] <= wdata;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign lk_m[g] = (ent_q[g].vpn == lk_vpn);
        assign sr_m[g] = (ent_q[g].vpn == sr_vpn);
    end

    tlb_prio_enc #(.N(N), .IW(IW)) u_lk_enc (.req(lk_m), .any(lk_hit), .idx(lk_idx));
    tlb_prio_enc #(.N(N), .IW(IW)) u_sr_enc (.req(sr_m), .any(sr_hit), .idx(sr_idx));

    assign lk_entry = ent_q[lk_idx];
    assign rdata    = ent_q[ridx];

endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int RSVD    = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xl_req,
    input  logic [31:0] xl_vaddr,
    input  logic        xl_store,
    output logic [29:0] xl_paddr,
    output logic [1:0]  xl_fault,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] index_o,
    output logic [31:0] entry_hi_o,
    output logic [31:0] entry_lo_o,
    output logic [31:0] bad_addr_o
);
    localparam int PAD_W = REG_W - 1 - IDX_W;

    // Management registers
    logic             idx_miss_q;
    logic [IDX_W-1:0] idx_slot_q;
    logic [VPN_W-1:0] hi_vpn_q;
    logic [PFN_W-1:0] lo_pfn_q;
    logic             lo_wen_q;
    logic             lo_vld_q;
    logic [VA_W-1:0]  bad_q;

    // Array hookup
    logic [IDX_W-1:0] rnd_slot;
    logic             arr_we;
    logic [IDX_W-1:0] arr_widx;
    tlb_entry_t       arr_wdata;
    tlb_entry_t       arr_rdata;
    logic             lk_hit;
    tlb_entry_t       lk_entry;
    logic             sr_hit;
    logic [IDX_W-1:0] sr_idx;

    tlb_op_e          op;
    tlb_sel_e         sel;
    tlb_fault_e       fault;
    logic             unmapped;
    logic             fault_fire;

    assign op  = tlb_op_e'(cmd_op);
    assign sel = tlb_sel_e'(reg_sel);

    tlb_rand_ctr #(.N(ENTRIES), .RSVD(RSVD), .IW(IDX_W)) u_rand (
        .clk(clk), .rst(rst), .slot_o(rnd_slot)
    );

    assign arr_we    = cmd_valid && (op == OP_WR_RAND || op == OP_WR_IDX);
    assign arr_widx  = (op == OP_WR_RAND) ? rnd_slot : idx_slot_q;
    assign arr_wdata = '{vpn: hi_vpn_q, pfn: lo_pfn_q, wen: lo_wen_q, vld: lo_vld_q};

    tlb_entry_array #(.N(ENTRIES), .IW(IDX_W)) u_array (
        .clk(clk), .rst(rst),
        .we(arr_we), .widx(arr_widx), .wdata(arr_wdata),
        .ridx(idx_slot_q), .rdata(arr_rdata),
        .lk_vpn(xl_vaddr[VA_W-1:PAGE_W]), .lk_hit(lk_hit), .lk_entry(lk_entry),
        .sr_vpn(hi_vpn_q), .sr_hit(sr_hit), .sr_idx(sr_idx)
    );

    // Translation path
    assign unmapped = is_unmapped(xl_vaddr);

    always_comb begin
        fault = FLT_NONE;
        if (xl_req && !unmapped) begin
            if (!lk_hit)                        fault = FLT_MISS;
            else if (!lk_entry.vld)             fault = FLT_INVALID;
            else if (xl_store && !lk_entry.wen) fault = FLT_WPROT;
        end
    end

    always_comb begin
        if (unmapped)               xl_paddr = xl_vaddr[PA_W-1:0];
        else if (fault == FLT_NONE) xl_paddr = {lk_entry.pfn, xl_vaddr[PAGE_W-1:0]};
        else                        xl_paddr = '0;
    end

    assign xl_fault   = fault;
    assign fault_fire = xl_req && (fault != FLT_NONE);

    // Register updates: software write < command < fault (later wins)
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_miss_q <= 1'b0;
            idx_slot_q <= '0;
            hi_vpn_q   <= '0;
            lo_pfn_q   <= '0;
            lo_wen_q   <= 1'b0;
            lo_vld_q   <= 1'b0;
            bad_q      <= '0;
        end else begin
            if (reg_we) begin
                unique case (sel)
                    SEL_INDEX: begin
                        idx_miss_q <= reg_wdata[REG_W-1];
                        idx_slot_q <= reg_wdata[IDX_W-1:0];
                    end
                    SEL_HI: hi_vpn_q <= reg_wdata[VA_W-1:PAGE_W];
                    SEL_LO: begin
                        lo_pfn_q <= reg_wdata[PA_W-1:PAGE_W];
                        lo_wen_q <= reg_wdata[1];
                        lo_vld_q <= reg_wdata[0];
                    end
                    default: ;
                endcase
            end
            if (cmd_valid) begin
                unique case (op)
                    OP_SEARCH: begin
                        idx_miss_q <= !sr_hit;
                        idx_slot_q <= sr_hit ? sr_idx : '0;
                    end
                    OP_RD_IDX: begin
                        hi_vpn_q <= arr_rdata.vpn;
                        lo_pfn_q <= arr_rdata.pfn;
                        lo_wen_q <= arr_rdata.wen;
                        lo_vld_q <= arr_rdata.vld;
                    end
                    default: ;
                endcase
            end
            if (fault_fire) begin
                hi_vpn_q <= xl_vaddr[VA_W-1:PAGE_W];
                bad_q    <= xl_vaddr;
            end
        end
    end

    assign index_o    = {idx_miss_q, {PAD_W{1'b0}}, idx_slot_q};
    assign entry_hi_o = pack_hi(hi_vpn_q);
    assign entry_lo_o = pack_lo(lo_pfn_q, lo_wen_q, lo_vld_q);
    assign bad_addr_o = bad_q;

    p_bypass_keeps_bad_r2: assert property (@(posedge clk) disable iff (rst)
        xl_req && unmapped |=> bad_addr_o == $past(bad_addr_o));

    p_fault_records_r5: assert property (@(posedge clk) disable iff (rst)
        xl_req && xl_fault != 2'd0 |=> bad_addr_o == $past(xl_vaddr));

    p_search_miss_flag_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && op == OP_SEARCH && !sr_hit |=> index_o[REG_W-1]);

    p_fault_beats_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        xl_req && xl_fault != 2'd0 && (cmd_valid || reg_we)
        |=> entry_hi_o[VA_W-1:PAGE_W] == $past(xl_vaddr[VA_W-1:PAGE_W]));

endmodule

// File: tb/tlb_mmu_tb.sv
module tlb_mmu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xl_req = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic        xl_store = 1'b0;
    logic [29:0] xl_paddr;
    logic [1:0]  xl_fault;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] index_o, entry_hi_o, entry_lo_o, bad_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [4:0]  mc;            // expected random counter
    logic [31:0] exp_bad = '0;

    tlb_mmu dut_i (
        .clk(clk), .rst(rst), .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_store(xl_store),
        .xl_paddr(xl_paddr), .xl_fault(xl_fault), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .index_o(index_o),
        .entry_hi_o(entry_hi_o), .entry_lo_o(entry_lo_o), .bad_addr_o(bad_addr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst)          mc <= 5'd4;
        else if (mc == 31) mc <= 5'd4;
        else              mc <= mc + 5'd1;
    end

    function automatic logic [19:0] s_vpn(int i); return 20'h00100 + 20'(i); endfunction
    function automatic logic [17:0] s_pfn(int i); return 18'((i * 37 + 5) * 1031); endfunction
    function automatic logic s_vld(int i); return (i % 5) != 0; endfunction
    function automatic logic s_wen(int i); return (i % 3) != 0; endfunction
    function automatic logic [31:0] lo_word(logic [17:0] p, logic w, logic v);
        return {2'b00, p, 10'b0, w, v};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] s, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic do_cmd(logic [1:0] op);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic xlate(logic [31:0] va, logic st, output logic [29:0] pa, output logic [1:0] f);
        @(negedge clk); xl_req = 1'b1; xl_vaddr = va; xl_store = st;
        #1; pa = xl_paddr; f = xl_fault;
        @(negedge clk); xl_req = 1'b0;
        if (f != 2'd0) exp_bad = va;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [29:0] pa;
        logic [1:0]  f;
        logic [4:0]  exp_slot;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 index", index_o, 32'h0);
        chk("R11 hi", entry_hi_o, 32'h0);
        chk("R11 lo", entry_lo_o, 32'h0);
        chk("R11 bad", bad_addr_o, 32'h0);
        xlate(32'h0000_1000, 1'b0, pa, f);
        chk("R11/R3 miss after reset", 32'(f), 32'd1);

        // R9 register formats
        wr_reg(2'd1, 32'hFFFF_FFFF); chk("R9 hi mask", entry_hi_o, 32'hFFFF_F000);
        wr_reg(2'd2, 32'hFFFF_FFFF); chk("R9 lo mask", entry_lo_o, 32'h3FFF_F003);
        wr_reg(2'd0, 32'hFFFF_FFFF); chk("R9 index mask", index_o, 32'h8000_001F);

        // R8 fill every slot by index
        for (int i = 0; i < N; i++) begin
            wr_reg(2'd0, 32'(i));
            wr_reg(2'd1, {s_vpn(i), 12'h0});
            wr_reg(2'd2, lo_word(s_pfn(i), s_wen(i), s_vld(i)));
            do_cmd(2'd3);
        end

        // R1 R4 R5 translate each slot, load and store
        for (int i = 0; i < N; i++) begin
            for (int st = 0; st < 2; st++) begin
                logic [11:0] off;
                logic [1:0]  ef;
                logic [31:0] va;
                off = 12'((i * 123 + st * 77) & 12'hFFF);
                va  = {s_vpn(i), off};
                ef  = !s_vld(i) ? 2'd2 : (st == 1 && !s_wen(i)) ? 2'd3 : 2'd0;
                xlate(va, st[0], pa, f);
                chk("R1/R4 fault code", 32'(f), 32'(ef));
                if (ef == 2'd0) chk("R1 paddr", 32'(pa), 32'({s_pfn(i), off}));
                else begin
                    chk("R5 hi on fault", entry_hi_o, {s_vpn(i), 12'h0});
                    chk("R5 bad on fault", bad_addr_o, va);
                end
            end
        end

        // R3 miss on unmapped page
        xlate(32'h0ABC_D123, 1'b1, pa, f);
        chk("R3 miss code", 32'(f), 32'd1);
        chk("R5 bad after miss", bad_addr_o, 32'h0ABC_D123);

        // R2 bypass window
        for (int k = 0; k < 4; k++) begin
            logic [31:0] va;
            va = 32'hC000_0000 | 32'(k * 32'h0F13_579B);
            xlate(va, k[0], pa, f);
            chk("R2 bypass fault", 32'(f), 32'd0);
            chk("R2 bypass paddr", 32'(pa), 32'(va[29:0]));
            chk("R2 bad unchanged", bad_addr_o, exp_bad);
        end

        // R8 read back every slot; R6 search every slot
        for (int i = 0; i < N; i++) begin
            wr_reg(2'd0, 32'(i));
            do_cmd(2'd2);
            chk("R8 read hi", entry_hi_o, {s_vpn(i), 12'h0});
            chk("R8 read lo", entry_lo_o, lo_word(s_pfn(i), s_wen(i), s_vld(i)));
            wr_reg(2'd0, 32'h8000_0000);
            do_cmd(2'd0);
            chk("R6 search hit", index_o, 32'(i));
        end
        wr_reg(2'd1, 32'h7777_7000);
        do_cmd(2'd0);
        chk("R6 search miss", index_o, 32'h8000_0000);

        // R7 random writes, enough to wrap the counter
        for (int k = 0; k < 30; k++) begin
            wr_reg(2'd1, {20'h06000 + 20'(k), 12'h0});
            wr_reg(2'd2, lo_word(18'(k + 1), 1'b1, 1'b1));
            @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd1; exp_slot = mc;
            @(negedge clk); cmd_valid = 1'b0;
            repeat (k % 3) @(negedge clk);
            do_cmd(2'd0);
            chk("R7 random slot", index_o, 32'(exp_slot));
        end
        for (int i = 0; i < 4; i++) begin
            wr_reg(2'd0, 32'(i));
            do_cmd(2'd2);
            chk("R7 low slot untouched", entry_hi_o, {s_vpn(i), 12'h0});
        end

        // R10 fault and read-slot on same edge
        wr_reg(2'd0, 32'd1);
        @(negedge clk);
        xl_req = 1'b1; xl_vaddr = 32'h1234_5678; xl_store = 1'b0;
        cmd_valid = 1'b1; cmd_op = 2'd2;
        @(negedge clk);
        xl_req = 1'b0; cmd_valid = 1'b0;
        chk("R10 hi from fault over read", entry_hi_o, 32'h1234_5000);
        chk("R10 lo from read", entry_lo_o, lo_word(s_pfn(1), s_wen(1), s_vld(1)));
        chk("R10 bad", bad_addr_o, 32'h1234_5678);

        // R10 fault and register write on same edge
        @(negedge clk);
        xl_req = 1'b1; xl_vaddr = 32'h2468_A000; xl_store = 1'b1;
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'hAAAA_A000;
        @(negedge clk);
        xl_req = 1'b0; reg_we = 1'b0;
        chk("R10 hi from fault over write", entry_hi_o, 32'h2468_A000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule